// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns two signed parallel audio samples, one for the left channel and one for the right, into a single serial data line in I2S format. A bit clock and a word-select line come from outside the block. Word select toggles once every WIDTH bit clocks: it is high while the right word is on the line and low while the left word is on the line. The block never counts bits. Each word-select change starts a new word, and the block moves that word out most significant bit (the sign bit) first, one bit clock late. Because of this lag, the last bit of the word that just ended is still on the line during the first bit period after word select changes.

Each channel holds its current sample in a register that a load strobe updates. A load strobe is usually timed to a word boundary, but it can arrive at any falling edge. Once a word has been copied into the shift register it cannot be changed. A new sample waits for the next slot of its own channel. All state changes on the falling edge of the bit clock, so the far end can sample on the rising edge. An active-high synchronous reset clears the block.

Top module: `stx_serializer`

## Requirements
- R1: While `rst` is high at a falling edge of `bitClk`, the block clears `serData`, the shift register, both held samples and the stored word-select history to 0. `serData` then stays 0 until a newly loaded sample is sent.
- R2: `serData` changes only on a falling edge of `bitClk` and is stable across every rising edge.
- R3: In the first bit period after `wordSel` changes, `serData` carries bit 0 of the word from the channel whose slot just ended.
- R4: In bit period k after a `wordSel` change (k = 1 .. WIDTH-1), `serData` carries bit WIDTH-k of the current word. The word therefore goes out sign bit first, from bit WIDTH-1 down to bit 1.
- R5: The current word is the held sample of the right channel when `wordSel` is 1 and of the left channel when `wordSel` is 0. It is copied into the shift register at the first falling edge after the change.
- R6: A high `loadLeft` (`loadRight`) at a falling edge copies `leftIn` (`rightIn`) into that channel's held sample. If the strobe arrives at the same edge that starts that channel's word, the old sample is sent and the new one waits for the channel's next slot.
- R7: A load strobe during a slot does not alter the word being sent in that slot. It also leaves the other channel's held sample unchanged.
- R8: If `wordSel` stays unchanged for more than WIDTH bit periods, `serData` is 0 after bit 0 of the word has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| wordSel | input | 1 | Channel select from outside: 1 = right slot, 0 = left slot |
| loadLeft | input | 1 | Copies `leftIn` into the left held sample |
| loadRight | input | 1 | Copies `rightIn` into the right held sample |
| leftIn | input | WIDTH | Signed left-channel sample |
| rightIn | input | WIDTH | Signed right-channel sample |
| serData | output | 1 | Serial data line, sign bit first, one bit clock behind `wordSel` |

## Verification
The embedded properties check three things on every falling edge. The line gets the sign bit of the selected held sample right after a word-select change. Otherwise it gets the next bit of the shift register. Each held sample takes its input exactly when strobed and keeps its value otherwise. The reset clear is also checked at every edge. Only the bench scenarios can show the behaviour seen from outside the block. These are the one-bit lag at each slot boundary and the sample chosen when a load coincides with a boundary. They also cover the undisturbed word after a load in the middle of a slot, the zeros in an over-long slot, the silence after a reset in the middle of the stream, and the stable line at each rising edge.

// File: rtl/stx_pkg.sv
package stx_pkg;

  // Channel indices used by the held-sample array.
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;
  localparam int CH_COUNT = 2;

  // Strobes from the slot control to the datapath.
  typedef struct packed {
    logic loadShift;  // a new slot begins: copy the selected sample
    logic pickRight;  // 1: right sample, 0: left sample
  } stxCtl_t;

endpackage

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
(
  input  logic    bitClk,
  input  logic    rst,
  input  logic    wordSel,
  output stxCtl_t ctl
);

  // Word select seen at the previous falling edge.
  logic wsPrev;

  always_ff @(negedge bitClk) begin
    if (rst) wsPrev <= 1'b0;
    else     wsPrev <= wordSel;
  end

  // A change between two falling edges opens the slot one bit late.
  always_comb begin
    ctl.loadShift = !rst && (wordSel != wsPrev);
    ctl.pickRight = wordSel;
  end

endmodule

// File: rtl/stx_datapath.sv
module stx_datapath
  import stx_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             bitClk,
  input  logic             rst,
  input  stxCtl_t          ctl,
  input  logic [CH_COUNT-1:0] loadVec,
  input  logic [WIDTH-1:0] sampleVec [CH_COUNT],
  output logic             serData
);

  // Bits still to send once the sign bit is on the line.
  localparam int REST = WIDTH - 1;

  logic [WIDTH-1:0] holdVec [CH_COUNT];
  logic [WIDTH-1:0] selWord;
  logic [REST-1:0]  shiftReg;

  // One held sample per channel.
  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_hold
    always_ff @(negedge bitClk) begin
      if (rst)              holdVec[ch] <= '0;
      else if (loadVec[ch]) holdVec[ch] <= sampleVec[ch];
    end

    p_hold_take_r6 : assert property (@(negedge bitClk) disable iff (rst)
      loadVec[ch] |=> holdVec[ch] == $past(sampleVec[ch]))
      else $error("held sample %0d missed its load", ch);

    p_hold_keep_r7 : assert property (@(negedge bitClk) disable iff (rst)
      !loadVec[ch] |=> $stable(holdVec[ch]))
      else $error("held sample %0d changed without a load", ch);
  end

  always_comb selWord = ctl.pickRight ? holdVec[CH_RIGHT] : holdVec[CH_LEFT];

  // The sign bit goes straight to the line; the rest shifts out behind it.
  always_ff @(negedge bitClk) begin
    if (rst) begin
      serData  <= 1'b0;
      shiftReg <= '0;
    end else if (ctl.loadShift) begin
      serData  <= selWord[WIDTH-1];
      shiftReg <= selWord[REST-1:0];
    end else begin
      serData  <= shiftReg[REST-1];
      shiftReg <= {shiftReg[REST-2:0], 1'b0};
    end
  end

  p_sign_first_r4 : assert property (@(negedge bitClk) disable iff (rst)
    ctl.loadShift |=> serData == $past(selWord[WIDTH-1]))
    else $error("slot did not open with the sign bit");

  p_shift_next_r4 : assert property (@(negedge bitClk) disable iff (rst)
    !ctl.loadShift |=> serData == $past(shiftReg[REST-1]))
    else $error("line did not take the next shifted bit");

  // Reset clear, checked one edge after reset was seen.
  logic rstSeen;
  always_ff @(negedge bitClk) rstSeen <= rst;

  always @(negedge bitClk) begin
    if (rstSeen === 1'b1) begin
      p_reset_clears_r1 : assert (serData == 1'b0 && shiftReg == '0 &&
                                  holdVec[CH_LEFT] == '0 && holdVec[CH_RIGHT] == '0)
        else $error("state not cleared by reset");
    end
  end

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
  import stx_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic                    bitClk,
  input  logic                    rst,
  input  logic                    wordSel,
  input  logic                    loadLeft,
  input  logic                    loadRight,
  input  logic signed [WIDTH-1:0] leftIn,
  input  logic signed [WIDTH-1:0] rightIn,
  output logic                    serData
);

  stxCtl_t             ctl;
  logic [CH_COUNT-1:0] loadVec;
  logic [WIDTH-1:0]    sampleVec [CH_COUNT];

  assign loadVec[CH_LEFT]    = loadLeft;
  assign loadVec[CH_RIGHT]   = loadRight;
  assign sampleVec[CH_LEFT]  = leftIn;
  assign sampleVec[CH_RIGHT] = rightIn;

  stx_ctrl i_ctrl (
    .bitClk (bitClk),
    .rst    (rst),
    .wordSel(wordSel),
    .ctl    (ctl)
  );

  stx_datapath #(.WIDTH(WIDTH)) i_datapath (
    .bitClk   (bitClk),
    .rst      (rst),
    .ctl      (ctl),
    .loadVec  (loadVec),
    .sampleVec(sampleVec),
    .serData  (serData)
  );

endmodule

// File: tb/test_stx_serializer.sv
module test_stx_serializer;

  localparam int W = 8;

  logic                bitClk = 1'b0;
  logic                rst = 1'b1;
  logic                wordSel = 1'b0;
  logic                loadLeft = 1'b0;
  logic                loadRight = 1'b0;
  logic signed [W-1:0] leftIn = '0;
  logic signed [W-1:0] rightIn = '0;
  logic                serData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 bitClk = ~bitClk;

  stx_serializer #(.WIDTH(W)) i_stx_serializer (
    .bitClk(bitClk), .rst(rst), .wordSel(wordSel),
    .loadLeft(loadLeft), .loadRight(loadRight),
    .leftIn(leftIn), .rightIn(rightIn), .serData(serData)
  );

  typedef struct {
    logic  bitv;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state, built from the requirements.
  logic [W-1:0] refLeft = '0, refRight = '0, curWord = '0;
  int           pos = -1;
  logic         wsLast = 1'b0;
  bit           rstPend = 1'b1;

  // One bit period: drive the inputs at the falling edge and push the line value for this period.
  task automatic step(input bit ws, input bit ldL, input bit ldR,
                      input logic [W-1:0] val, input bit rstV, input string phase);
    expItem_t it;
    @(negedge bitClk);
    wordSel   <= ws;
    loadLeft  <= ldL;
    loadRight <= ldR;
    leftIn    <= val;
    rightIn   <= val;
    rst       <= rstV;
    if (rstPend) begin
      it.bitv = 1'b0; it.tag = "R1";
      refLeft = '0; refRight = '0; curWord = '0; pos = -1;
    end else if (ws != wsLast) begin
      it.bitv = (pos >= 0) ? curWord[pos] : 1'b0;
      it.tag  = "R3";
      curWord = ws ? refRight : refLeft;
      pos     = W - 1;
    end else if (pos >= 0) begin
      it.bitv = curWord[pos]; it.tag = "R4"; pos--;
    end else begin
      it.bitv = 1'b0; it.tag = "R8";
    end
    if (!rstV) begin
      if (ldL) refLeft  = val;
      if (ldR) refRight = val;
    end
    wsLast  = ws;
    rstPend = rstV;
    it.tag  = {it.tag, " [", phase, "]"};
    expQ.push_back(it);
  endtask

  // One slot: a change to ws, then len periods in total, with an optional load at index ldAt.
  task automatic slot(input bit ws, input int len, input int ldAt, input bit ldRight,
                      input logic [W-1:0] val, input string phase);
    for (int k = 0; k < len; k++)
      step(ws, (k == ldAt) && !ldRight, (k == ldAt) && ldRight, val, 1'b0, phase);
  endtask

  // Monitor: sample at the rising edge and check that the line holds until before the falling edge.
  initial begin
    forever begin
      @(posedge bitClk);
      if (expQ.size() > 0) begin
        expItem_t it;
        logic v0;
        it = expQ.pop_front();
        v0 = serData;
        checks++;
        if (v0 !== it.bitv) begin
          errors++;
          $display("FAIL %s: serData=%0b expected=%0b at %0t", it.tag, v0, it.bitv, $time);
        end
        #3;
        checks++;
        if (serData !== v0) begin
          errors++;
          $display("FAIL R2: serData=%0b moved after rising edge, expected=%0b", serData, v0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge bitClk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset, then idle.
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R1 reset");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R1 idle");
    step(1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, "R6 preload");
    step(1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, "R6 preload");
    // R5: right slot sends 3C.
    slot(1'b1, W, -1, 1'b0, '0, "R5 right");
    // R6: a left load at the edge that opens the left slot still sends A5.
    slot(1'b0, W, 0, 1'b0, 8'h11, "R6 same edge");
    // The left load at this boundary replaces 11 with 81.
    slot(1'b1, W, 0, 1'b0, 8'h81, "R5 right again");
    // R4: a negative left word goes out sign bit first.
    slot(1'b0, W, 0, 1'b1, 8'hFF, "R4 negative");
    // R7: a right load in the middle of the right slot leaves FF on the line.
    slot(1'b1, W, 3, 1'b1, 8'h00, "R7 mid slot");
    slot(1'b0, W, -1, 1'b0, '0, "R7 other channel kept");
    slot(1'b1, W, -1, 1'b0, '0, "R7 new right word");
    // R8: an over-long left slot ends in zeros.
    slot(1'b0, W + 3, -1, 1'b0, '0, "R8 long slot");
    slot(1'b1, W, 0, 1'b1, 8'h6E, "R5 after long");
    slot(1'b0, 4, -1, 1'b0, '0, "R1 before reset");
    // R1: reset in the middle of a slot clears the held samples as well.
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R1 mid reset");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R1 after reset");
    slot(1'b1, W, -1, 1'b0, '0, "R1 cleared right");
    slot(1'b0, W, -1, 1'b0, '0, "R1 cleared left");
    slot(1'b1, W, 0, 1'b1, 8'h5A, "R6 reload");
    slot(1'b0, W, -1, 1'b0, '0, "R3 tail");
    slot(1'b1, W, -1, 1'b0, '0, "R5 reloaded right");
    slot(1'b0, 2, -1, 1'b0, '0, "R3 final tail");
    repeat (3) @(posedge bitClk);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule